// File: doc/BRIEF.md
# Wide Dual-Port Memory with 16-bit Sliced Bus View

This block stores `DEPTH` entries of `WIDTH` bits. A user port sees each entry whole: one address, one full-width write word, one write enable and one full-width read word. A register bus port sees the same storage as 16-bit slices. Internally the entry is cut into `ceil(WIDTH/16)` parallel RAM banks of equal depth. Bank 0 holds the least significant 16 bits. The top bank holds whatever bits are left over.

On the bus, the banks sit one after another in depth-sized windows that start at the parameter `BASE`. Slice `i` of user row `a` is therefore found at bus address `BASE + a + i*DEPTH`. Addresses outside the window are left alone, and read data stays at zero for them, so several such blocks can be OR-ed onto one shared bus.

A mode parameter sets which side may write and which side may read. After every reset a sweep writes zeros into every row before either port is allowed to act.

Top module: `wide_slice_ram`

## Requirements
- R1: Bank `i` holds bits `[16*i+15:16*i]` of each entry. Slice `i` of user row `a` is at bus address `BASE + a + i*DEPTH`.
- R2: When `WIDTH` is not a multiple of 16, the top bank stores `WIDTH mod 16` bits. Bits above that width read back as zero on the bus, even if they were written as ones.
- R3: After reset is released, a clear sweep of `DEPTH` cycles writes zero to every row. Reads and writes from either port during the sweep are ignored. Afterwards every location reads zero on both ports.
- R4: User reads are synchronous with two register stages. With `user_addr` applied before a rising edge, `user_rdata` shows that row after the second rising edge. After only the first edge it still shows the previous data.
- R5: A `bus_rd` strobe at an in-window address raises `bus_rvalid` for exactly one cycle, after the second rising edge, with the slice on `bus_rdata`. A `bus_wr` strobe writes at the rising edge where it is high.
- R6: Bus addresses below `BASE` or at or above `BASE + NB*DEPTH` are ignored. Writes there change no row, and reads there produce no `bus_rvalid`.
- R7: `bus_rdata` is zero in every cycle where `bus_rvalid` is low.
- R8: A full-width user write appears slice by slice at the matching bus addresses. Bus writes to the slices of a row reassemble into the full value at the user read port.
- R9: When both ports write the same row of a bank in the same cycle, the user port's data is stored. Writes to different rows in the same cycle both take effect.
- R10: `MODE` takes one of three codes: 0 allows both sides to read and write, 1 lets only the user side write and only the bus read, 2 lets only the bus write and only the user side read. In mode 1, bus writes are ignored and `user_rdata` stays zero. In mode 2, user writes are ignored and `bus_rvalid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| user_addr | input | RW = clog2(DEPTH) | User row address |
| user_wdata | input | WIDTH | Full-width user write data |
| user_we | input | 1 | User write enable |
| user_rdata | output | WIDTH | Full-width user read data, two cycles after the address |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wdata | input | 16 | Bus write slice |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdata | output | 16 | Bus read slice; zero when not valid |
| bus_rvalid | output | 1 | One-cycle flag marking bus read data |

## Verification
The bound checker watches the bus side on every cycle. It checks that `bus_rvalid` only follows a read strobe from two cycles earlier and never follows an out-of-window strobe. It checks that read data is zero whenever it is not valid, that the padding bits of the top bank stay clear, and that mode 2 never returns bus data. Slice placement, reassembly, write collisions, the clear sweep and the user read latency depend on stored contents. Only the bench scenarios can show those, by writing through one port and reading back through the other.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [1:0] {
    MODE_BIDIR   = 2'd0,
    MODE_USER_WR = 2'd1,
    MODE_BUS_WR  = 2'd2
  } mode_e;

  localparam int SLICE_W = 16;

  function automatic int bank_count(input int width);
    return (width + SLICE_W - 1) / SLICE_W;
  endfunction

  function automatic int row_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/wsr_clear.sv
module wsr_clear #(
  parameter int DEPTH = 12,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic          active,
  output logic [RW-1:0] row
);

  localparam logic [RW-1:0] LAST = RW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      row    <= '0;
    end else if (active) begin
      if (row == LAST) begin
        active <= 1'b0;
        row    <= '0;
      end else begin
        row <= row + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wsr_bus_decode.sv
module wsr_bus_decode #(
  parameter int                ADDR_W = 16,
  parameter int                DEPTH  = 12,
  parameter int                NB     = 3,
  parameter int                RW     = 4,
  parameter logic [ADDR_W-1:0] BASE   = 'h0100
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [NB-1:0]     sel,
  output logic [RW-1:0]     row
);

  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(NB * DEPTH);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE;
    hit = (addr >= BASE) && (off < WIN);
    sel = '0;
    row = '0;
    for (int i = 0; i < NB; i++) begin
      if (hit && (off >= ADDR_W'(i * DEPTH)) && (off < ADDR_W'((i + 1) * DEPTH))) begin
        sel[i] = 1'b1;
        row    = RW'(off - ADDR_W'(i * DEPTH));
      end
    end
  end

endmodule

// File: rtl/wsr_bank.sv
module wsr_bank #(
  parameter int BW    = 16,
  parameter int DEPTH = 12,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [RW-1:0] clr_row,
  input  logic          u_we,
  input  logic [RW-1:0] u_row,
  input  logic [BW-1:0] u_wd,
  input  logic          b_we,
  input  logic [RW-1:0] b_row,
  input  logic [BW-1:0] b_wd,
  output logic [BW-1:0] u_q,
  output logic [BW-1:0] b_q
);

  logic [BW-1:0] mem [DEPTH];

  // The user write is issued last, so it wins a same-row collision.
  always_ff @(posedge clk) begin
    if (clr) begin
      mem[clr_row] <= '0;
    end else begin
      if (b_we) mem[b_row] <= b_wd;
      if (u_we) mem[u_row] <= u_wd;
    end
  end

  always_ff @(posedge clk) begin
    u_q <= mem[u_row];
    b_q <= mem[b_row];
  end

endmodule

// File: rtl/wide_slice_ram.sv
module wide_slice_ram #(
  parameter int                WIDTH  = 40,
  parameter int                DEPTH  = 12,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'h0100,
  parameter wsr_pkg::mode_e    MODE   = wsr_pkg::MODE_BIDIR,
  localparam int               RW     = wsr_pkg::row_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RW-1:0]     user_addr,
  input  logic [WIDTH-1:0]  user_wdata,
  input  logic              user_we,
  output logic [WIDTH-1:0]  user_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int NB   = wsr_pkg::bank_count(WIDTH);
  localparam int TOPW = WIDTH - 16 * (NB - 1);
  localparam bit USER_CAN_WR = (MODE != wsr_pkg::MODE_BUS_WR);
  localparam bit USER_CAN_RD = (MODE != wsr_pkg::MODE_USER_WR);
  localparam bit BUS_CAN_WR  = (MODE != wsr_pkg::MODE_USER_WR);
  localparam bit BUS_CAN_RD  = (MODE != wsr_pkg::MODE_BUS_WR);

  logic          clr_active;
  logic [RW-1:0] clr_row;

  wsr_clear #(.DEPTH(DEPTH), .RW(RW)) u_clear (
    .clk    (clk),
    .rst    (rst),
    .active (clr_active),
    .row    (clr_row)
  );

  logic          b_hit;
  logic [NB-1:0] b_sel;
  logic [RW-1:0] b_row;

  wsr_bus_decode #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .NB     (NB),
    .RW     (RW),
    .BASE   (BASE)
  ) u_dec (
    .addr (bus_addr),
    .hit  (b_hit),
    .sel  (b_sel),
    .row  (b_row)
  );

  logic u_we_eff, b_we_eff, b_rd_eff;

  assign u_we_eff = USER_CAN_WR && user_we && !clr_active && (32'(user_addr) < DEPTH);
  assign b_we_eff = BUS_CAN_WR && bus_wr && b_hit && !clr_active;
  assign b_rd_eff = BUS_CAN_RD && bus_rd && b_hit && !clr_active;

  logic [WIDTH-1:0] u_word;
  logic [15:0]      bq16 [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam int BW = (i == NB - 1) ? TOPW : 16;
    logic [BW-1:0] uq, bq;

    wsr_bank #(.BW(BW), .DEPTH(DEPTH), .RW(RW)) u_bank (
      .clk     (clk),
      .clr     (clr_active),
      .clr_row (clr_row),
      .u_we    (u_we_eff),
      .u_row   (user_addr),
      .u_wd    (user_wdata[16*i +: BW]),
      .b_we    (b_we_eff && b_sel[i]),
      .b_row   (b_row),
      .b_wd    (bus_wdata[BW-1:0]),
      .u_q     (uq),
      .b_q     (bq)
    );

    assign u_word[16*i +: BW] = uq;
    assign bq16[i]            = 16'(bq);
  end

  // Bus read pipeline: bank read at the first edge, slice select at the second.
  logic          rd_s1;
  logic [NB-1:0] sel_s1;
  logic [15:0]   bmux;

  always_comb begin
    bmux = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel_s1[i]) bmux = bmux | bq16[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1      <= 1'b0;
      sel_s1     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rd_s1      <= b_rd_eff;
      sel_s1     <= b_sel;
      bus_rvalid <= rd_s1;
      bus_rdata  <= rd_s1 ? bmux : 16'h0000;
    end
  end

  if (USER_CAN_RD) begin : g_user_rd
    always_ff @(posedge clk) begin
      if (rst) user_rdata <= '0;
      else     user_rdata <= u_word;
    end
  end else begin : g_user_no_rd
    assign user_rdata = '0;
  end

endmodule

// File: rtl/wide_slice_ram_chk.sv
module wide_slice_ram_chk #(
  parameter int                WIDTH  = 40,
  parameter int                DEPTH  = 12,
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 'h0100,
  parameter wsr_pkg::mode_e    MODE   = wsr_pkg::MODE_BIDIR
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [15:0]       bus_rdata,
  input logic              bus_rvalid
);

  localparam int NB     = wsr_pkg::bank_count(WIDTH);
  localparam int TOPW   = WIDTH - 16 * (NB - 1);
  localparam int LO     = int'(BASE);
  localparam int HI     = LO + NB * DEPTH;
  localparam int TOP_LO = LO + (NB - 1) * DEPTH;

  logic outside;
  assign outside = (int'(bus_addr) < LO) || (int'(bus_addr) >= HI);

  // R5: valid data only ever follows a read strobe two cycles back
  p_rvalid_from_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd, 2));

  // R6: strobes outside the window never produce valid data
  p_outside_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && outside) |=> ##1 !bus_rvalid);

  // R7: data lines stay quiet unless flagged valid
  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == 16'h0000));

  if (TOPW < 16) begin : g_pad
    // R2: padding bits of the narrow top bank read as zero
    p_top_pad_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_rvalid && (int'($past(bus_addr, 2)) >= TOP_LO)) |-> (bus_rdata[15:TOPW] == '0));
  end

  if (MODE == wsr_pkg::MODE_BUS_WR) begin : g_nord
    // R10: bus-writes-only mode returns nothing to the bus
    p_no_bus_read_r10: assert property (@(posedge clk) disable iff (rst)
      bus_rd |=> ##1 !bus_rvalid);
  end

endmodule

bind wide_slice_ram wide_slice_ram_chk #(
  .WIDTH  (WIDTH),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W),
  .BASE   (BASE),
  .MODE   (MODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid)
);

// File: tb/wide_slice_ram_test.sv
`timescale 1ns/1ps
module wide_slice_ram_test;

  localparam int W = 40;
  localparam int D = 12;
  localparam int BASEI = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  user_addr = '0;
  logic [W-1:0] user_wdata = '0;
  logic        user_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;

  logic [W-1:0] ur  [3];
  logic [15:0]  brd [3];
  logic         bv  [3];

  always #4 clk = ~clk;

  wide_slice_ram #(.WIDTH(W), .DEPTH(D), .ADDR_W(16), .BASE(16'h0100),
                   .MODE(wsr_pkg::MODE_BIDIR)) uut (
    .clk(clk), .rst(rst), .user_addr(user_addr), .user_wdata(user_wdata),
    .user_we(user_we), .user_rdata(ur[0]), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(brd[0]), .bus_rvalid(bv[0]));

  wide_slice_ram #(.WIDTH(W), .DEPTH(D), .ADDR_W(16), .BASE(16'h0100),
                   .MODE(wsr_pkg::MODE_USER_WR)) uut_uw (
    .clk(clk), .rst(rst), .user_addr(user_addr), .user_wdata(user_wdata),
    .user_we(user_we), .user_rdata(ur[1]), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(brd[1]), .bus_rvalid(bv[1]));

  wide_slice_ram #(.WIDTH(W), .DEPTH(D), .ADDR_W(16), .BASE(16'h0100),
                   .MODE(wsr_pkg::MODE_BUS_WR)) uut_bw (
    .clk(clk), .rst(rst), .user_addr(user_addr), .user_wdata(user_wdata),
    .user_we(user_we), .user_rdata(ur[2]), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(brd[2]), .bus_rvalid(bv[2]));

  int n_chk = 0;
  int n_fail = 0;
  logic [47:0] model [D];
  localparam logic [47:0] MASK = 48'h00FF_FFFF_FFFF;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_bus(input int a, input logic [15:0] d);
    int off = a - BASEI;
    if (off >= 0 && off < 3 * D) begin
      model[off % D][16 * (off / D) +: 16] = d;
      model[off % D] = model[off % D] & MASK;
    end
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = 16'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_bus(a, d);
  endtask

  task automatic user_write(input int r, input logic [W-1:0] d);
    @(negedge clk);
    user_addr = 4'(r); user_wdata = d; user_we = 1'b1;
    @(negedge clk);
    user_we = 1'b0;
    model[r] = {8'h00, d};
  endtask

  task automatic bus_read(input int a);
    @(negedge clk);
    bus_addr = 16'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic user_read(input int r);
    @(negedge clk);
    user_addr = 4'(r);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_clear;
    for (int r = 0; r < D; r++) model[r] = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R7 rvalid after reset", 64'(bv[0]), 64'd0);
    chk("R7 rdata after reset", 64'(brd[0]), 64'd0);
    chk("R3 user_rdata after reset", 64'(ur[0]), 64'd0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    bus_addr = 16'h0100; bus_wdata = 16'hDEAD; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (D + 2) @(negedge clk);
    bus_read(BASEI);
    chk("R3 write during clear ignored (valid)", 64'(bv[0]), 64'd1);
    chk("R3 write during clear ignored (data)", 64'(brd[0]), 64'd0);
    bus_read(BASEI + 3 * D - 1);
    chk("R3 last bus location zero", 64'(brd[0]), 64'd0);
    user_read(D - 1);
    chk("R3 last user row zero", 64'(ur[0]), 64'd0);
    user_read(0);
    chk("R3 first user row zero", 64'(ur[0]), 64'd0);
  endtask

  task automatic t_modes;
    user_write(1, 40'hA1_B2C3_D4E5);
    bus_write(BASEI + 1, 16'h7777);
    bus_read(BASEI + 1);
    chk("R10 mode0 bus slice", 64'(brd[0]), 64'h7777);
    chk("R10 mode1 bus write ignored", 64'(brd[1]), 64'hD4E5);
    chk("R10 mode1 bus read valid", 64'(bv[1]), 64'd1);
    chk("R10 mode2 no bus read valid", 64'(bv[2]), 64'd0);
    chk("R10 mode2 bus rdata quiet", 64'(brd[2]), 64'd0);
    user_read(1);
    chk("R10 mode0 user row", 64'(ur[0]), 64'(model[1][39:0]));
    chk("R10 mode1 user read zero", 64'(ur[1]), 64'd0);
    chk("R10 mode2 user write ignored", 64'(ur[2]), 64'h00_0000_7777);
  endtask

  task automatic t_user_to_bus;
    user_write(5, 40'h12_3456_789A);
    bus_read(BASEI + 5);
    chk("R1 slice0 at base+row", 64'(brd[0]), 64'h789A);
    bus_read(BASEI + 5 + D);
    chk("R8 slice1 at base+row+depth", 64'(brd[0]), 64'h3456);
    bus_read(BASEI + 5 + 2 * D);
    chk("R1 slice2 at base+row+2*depth", 64'(brd[0]), 64'h0012);
  endtask

  task automatic t_bus_to_user;
    bus_write(BASEI + 7, 16'hBEEF);
    bus_write(BASEI + 7 + D, 16'hCAFE);
    bus_write(BASEI + 7 + 2 * D, 16'hFFFF);
    user_read(7);
    chk("R8 slices reassemble", 64'(ur[0]), 64'hFF_CAFE_BEEF);
    bus_read(BASEI + 7 + 2 * D);
    chk("R2 top bank padding zero", 64'(brd[0]), 64'h00FF);
  endtask

  task automatic t_user_latency;
    user_write(2, 40'h11_2222_3333);
    user_write(3, 40'h44_5555_6666);
    user_read(2);
    chk("R4 row after two edges", 64'(ur[0]), 64'h11_2222_3333);
    user_addr = 4'd3;
    @(negedge clk);
    chk("R4 old data after one edge", 64'(ur[0]), 64'h11_2222_3333);
    @(negedge clk);
    chk("R4 new data after two edges", 64'(ur[0]), 64'h44_5555_6666);
  endtask

  task automatic t_bus_latency;
    @(negedge clk);
    bus_addr = 16'(BASEI + 5); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R5 no valid after first edge", 64'(bv[0]), 64'd0);
    @(negedge clk);
    chk("R5 valid after second edge", 64'(bv[0]), 64'd1);
    chk("R5 data after second edge", 64'(brd[0]), 64'h789A);
    @(negedge clk);
    chk("R5 valid is one cycle", 64'(bv[0]), 64'd0);
  endtask

  task automatic t_window;
    bus_write(BASEI - 1, 16'hAAAA);
    bus_write(BASEI + 3 * D, 16'hBBBB);
    bus_read(BASEI - 1);
    chk("R6 below window no valid", 64'(bv[0]), 64'd0);
    chk("R6 below window no data", 64'(brd[0]), 64'd0);
    bus_read(BASEI + 3 * D);
    chk("R6 above window no valid", 64'(bv[0]), 64'd0);
    user_read(0);
    chk("R6 row 0 untouched", 64'(ur[0]), 64'(model[0][39:0]));
    user_read(D - 1);
    chk("R6 last row untouched", 64'(ur[0]), 64'(model[D-1][39:0]));
  endtask

  task automatic t_collision;
    @(negedge clk);
    user_addr = 4'd4; user_wdata = 40'h9C_8B7A_6958; user_we = 1'b1;
    bus_addr = 16'(BASEI + 4); bus_wdata = 16'h5555; bus_wr = 1'b1;
    @(negedge clk);
    user_we = 1'b0; bus_wr = 1'b0;
    model[4] = 48'h9C_8B7A_6958;
    bus_read(BASEI + 4);
    chk("R9 user wins same row", 64'(brd[0]), 64'h6958);
    @(negedge clk);
    user_addr = 4'd6; user_wdata = 40'h01_0203_0405; user_we = 1'b1;
    bus_addr = 16'(BASEI + 9); bus_wdata = 16'h1234; bus_wr = 1'b1;
    @(negedge clk);
    user_we = 1'b0; bus_wr = 1'b0;
    model[6] = 48'h01_0203_0405;
    m_bus(BASEI + 9, 16'h1234);
    user_read(9);
    chk("R9 bus write other row lands", 64'(ur[0]), 64'(model[9][39:0]));
    user_read(6);
    chk("R9 user write other row lands", 64'(ur[0]), 64'h01_0203_0405);
  endtask

  task automatic t_sweep;
    for (int r = 0; r < D; r++)
      user_write(r, 40'h9A_5C3E_0F71 ^ (40'(r) * 40'h01_0203_0405));
    for (int a = BASEI; a < BASEI + 3 * D; a++) begin
      bus_read(a);
      chk("R1 sweep slice", 64'(brd[0]),
          64'(model[(a - BASEI) % D][16 * ((a - BASEI) / D) +: 16]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_clear();
    t_modes();
    t_user_to_bus();
    t_bus_to_user();
    t_user_latency();
    t_bus_latency();
    t_window();
    t_collision();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule